// File: doc/BRIEF.md
# SD Card Initialization Clock Sequencer

This block sits in an SD host controller beside the SD clock divider. It owns a single control bit that software sets to request the power-up clock burst a freshly inserted card needs. While that bit is set, the block holds a clock-enable override high. The SD clock then keeps running even when automatic clock gating would stop it. The block counts a fixed number of SD clock periods, using the tick-enable pulses from the divider, and then clears the bit by itself.

Software may issue a command while the burst is still running. The block does not reject that command. It holds the start request and releases it as a single start pulse once the last burst clock has gone out. This lets a driver queue its first command straight after setting the bit. When that command completes, the driver knows the burst is over.

Top module: `sd_init_clk_seq`

## Requirements
- R1: After reset, `init_active_o`, `clk_force_o` and `cmd_start_o` are all 0.
- R2: A write of 1 (`wr_en_i`=1, `wr_data_i`=1) while the bit is clear and both inhibit flags are 0 sets `init_active_o` in the next cycle.
- R3: While `init_active_o` is 1, `clk_force_o` is 1. The burst counts only cycles with `sd_tick_i`=1 while the bit is set, and it lasts exactly `BURST_LEN` such ticks (default 80). A tick in the arming cycle is not counted.
- R4: The bit stays 1 through the cycle that carries the `BURST_LEN`-th tick. It reads 0, with `clk_force_o` 0, from the next cycle on.
- R5: A write of 1 while the bit is set has no effect: the count neither restarts nor extends.
- R6: A write of 0 never changes the bit, so a running burst cannot be aborted.
- R7: A write of 1 is ignored while `cmd_inhibit_i` or `dat_inhibit_i` is 1.
- R8: While the bit is clear, `cmd_req_i` appears on `cmd_start_o` in the same cycle.
- R9: `cmd_start_o` is never 1 while the bit is set. Requests made during the burst, including one in the final tick cycle, produce exactly one `cmd_start_o` pulse in the cycle in which the bit first reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe for the control bit |
| wr_data_i | input | 1 | Value written to the control bit |
| cmd_inhibit_i | input | 1 | Command line busy flag |
| dat_inhibit_i | input | 1 | Data lines busy flag |
| sd_tick_i | input | 1 | One-cycle pulse per SD clock period from the divider |
| cmd_req_i | input | 1 | Command start request pulse |
| init_active_o | output | 1 | Live readback of the control bit |
| clk_force_o | output | 1 | Forces the SD clock to run, overriding gating |
| cmd_start_o | output | 1 | Start pulse to the command serializer |

## Verification
The bench builds the block with `BURST_LEN` = 80, the value a card expects, rather than a shortened count. The first burst spaces its ticks three system cycles apart. This leaves idle cycles in which the bench can write 1, write 0 and raise command requests, and it shows that cycles without a tick do not advance the count. The second burst uses one tick per cycle, including a tick in the arming cycle and a request in the final tick cycle. This reaches the boundary where deferral and self-clear meet.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sd_init_ctrl.sv
module sd_init_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_data_i,
  input  logic cmd_inhibit_i,
  input  logic dat_inhibit_i,
  input  logic last_i,
  output logic arm_o,
  output logic active_o
);
  logic active_q;

  // only a 1 written to an idle bit with quiet lines arms; 0 is never honoured
  assign arm_o = wr_en_i & wr_data_i & ~active_q & ~cmd_inhibit_i & ~dat_inhibit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= 1'b0;
    else if (arm_o)  active_q <= 1'b1;
    else if (last_i) active_q <= 1'b0;
  end

  assign active_o = active_q;
endmodule

// File: rtl/sd_init_burst_cnt.sv
module sd_init_burst_cnt #(
  parameter int BURST_LEN = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic last_o
);
  import sd_init_pkg::*;
  localparam int CNT_W = cnt_width(BURST_LEN);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(BURST_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = run_i & tick_i & (cnt_q == LAST_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clear_i)          cnt_q <= '0;
    else if (run_i && tick_i)  cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/sd_init_cmd_gate.sv
module sd_init_cmd_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic last_i,
  input  logic cmd_req_i,
  output logic cmd_start_o
);
  logic pend_q, release_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      release_q <= 1'b0;
    end else begin
      release_q <= last_i & (pend_q | cmd_req_i);
      if (last_i)                    pend_q <= 1'b0;
      else if (active_i && cmd_req_i) pend_q <= 1'b1;
    end
  end

  assign cmd_start_o = release_q | (cmd_req_i & ~active_i);
endmodule

// File: rtl/sd_init_clk_seq.sv
module sd_init_clk_seq #(
  parameter int BURST_LEN = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_data_i,
  input  logic cmd_inhibit_i,
  input  logic dat_inhibit_i,
  input  logic sd_tick_i,
  input  logic cmd_req_i,
  output logic init_active_o,
  output logic clk_force_o,
  output logic cmd_start_o
);
  logic arm, active, last;

  sd_init_ctrl i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .cmd_inhibit_i (cmd_inhibit_i),
    .dat_inhibit_i (dat_inhibit_i),
    .last_i        (last),
    .arm_o         (arm),
    .active_o      (active)
  );

  sd_init_burst_cnt #(.BURST_LEN(BURST_LEN)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (arm),
    .run_i   (active),
    .tick_i  (sd_tick_i),
    .last_o  (last)
  );

  sd_init_cmd_gate i_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .last_i      (last),
    .cmd_req_i   (cmd_req_i),
    .cmd_start_o (cmd_start_o)
  );

  assign init_active_o = active;
  assign clk_force_o   = active;
endmodule

// File: rtl/sd_init_clk_seq_chk.sv
module sd_init_clk_seq_chk #(
  parameter int BURST_LEN = 80
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic wr_data_i,
  input logic cmd_inhibit_i,
  input logic dat_inhibit_i,
  input logic sd_tick_i,
  input logic cmd_req_i,
  input logic init_active_o,
  input logic clk_force_o,
  input logic cmd_start_o
);
  import sd_init_pkg::*;
  localparam int SEEN_W = cnt_width(BURST_LEN) + 1;

  logic [SEEN_W-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          seen_q <= '0;
    else if (!init_active_o)              seen_q <= '0;
    else if (sd_tick_i)                   seen_q <= seen_q + 1'b1;
  end

  AST_ARM_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_active_o && wr_en_i && wr_data_i && !cmd_inhibit_i && !dat_inhibit_i)
      |=> init_active_o); // R2

  AST_BURST_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(init_active_o) |-> (seen_q == SEEN_W'(BURST_LEN) && !clk_force_o)); // R3

  AST_NO_CLEAR_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_active_o && !sd_tick_i) |=> init_active_o); // R6

  AST_INHIBIT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_active_o && wr_en_i && (cmd_inhibit_i || dat_inhibit_i)) |=> !init_active_o); // R7

  AST_NO_START_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_active_o |-> !cmd_start_o); // R9

  AST_IDLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_active_o && cmd_req_i) |-> cmd_start_o); // R8
endmodule

bind sd_init_clk_seq sd_init_clk_seq_chk #(.BURST_LEN(BURST_LEN)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .cmd_inhibit_i (cmd_inhibit_i),
  .dat_inhibit_i (dat_inhibit_i),
  .sd_tick_i     (sd_tick_i),
  .cmd_req_i     (cmd_req_i),
  .init_active_o (init_active_o),
  .clk_force_o   (clk_force_o),
  .cmd_start_o   (cmd_start_o)
);

// File: tb/test_sd_init_clk_seq.sv
module test_sd_init_clk_seq;
  localparam int LEN = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_data = 0, cmd_inh = 0, dat_inh = 0, tick = 0, cmd_req = 0;
  logic init_active, clk_force, cmd_start;
  int cyc = 0, n_chk = 0, n_fail = 0;
  int exp_q[$];
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sd_init_clk_seq #(.BURST_LEN(LEN)) i_sd_init_clk_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .cmd_inhibit_i(cmd_inh), .dat_inhibit_i(dat_inh), .sd_tick_i(tick),
    .cmd_req_i(cmd_req), .init_active_o(init_active), .clk_force_o(clk_force),
    .cmd_start_o(cmd_start)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: every start pulse must match the next expected cycle
  always @(negedge clk) begin
    if (rst_n && cmd_start) begin
      if (exp_q.size() == 0) check("R9 unexpected start", cyc, -1);
      else check("R8/R9 start cycle", cyc, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
    finish_run();
  end

  initial begin
    repeat (3) step();
    @(negedge clk);
    check("R1 active", init_active, 0);
    check("R1 force", clk_force, 0);
    check("R1 start", cmd_start, 0);
    step(); rst_n = 1;
    step();

    // R8: idle request passes straight through
    cmd_req = 1; exp_q.push_back(cyc);
    step(); cmd_req = 0;
    step();

    // R7: writes of 1 under either inhibit are dropped
    cmd_inh = 1; wr_en = 1; wr_data = 1;
    step(); cmd_inh = 0; dat_inh = 1;
    step(); dat_inh = 0; wr_en = 0; wr_data = 0;
    @(negedge clk); check("R7 inhibit ignored", init_active, 0);
    step();
    wr_en = 1; wr_data = 0;
    step(); wr_en = 0;
    @(negedge clk); check("R6 write0 idle", init_active, 0);
    step();

    // burst 1: ticks every third cycle
    wr_en = 1; wr_data = 1;
    step(); wr_en = 0; wr_data = 0;
    @(negedge clk);
    check("R2 armed", init_active, 1);
    check("R3 force on", clk_force, 1);
    step(); step();
    for (int i = 1; i <= LEN; i++) begin
      tick = 1;
      if (i == LEN) begin
        exp_q.push_back(cyc + 1);
        @(negedge clk); check("R4 set through last tick", init_active, 1);
        step(); tick = 0;
        break;
      end
      step(); tick = 0;
      if (i == 10) begin wr_en = 1; wr_data = 1; end   // R5
      if (i == 20) begin wr_en = 1; wr_data = 0; end   // R6
      if (i == 30 || i == 40) cmd_req = 1;             // R9
      step(); wr_en = 0; wr_data = 0; cmd_req = 0;
      if (i == 20) begin @(negedge clk); check("R6 write0 no abort", init_active, 1); end
      if (i == LEN - 1) begin @(negedge clk); check("R3/R5 no early clear", init_active, 1); end
      step();
    end
    @(negedge clk);
    check("R4 self clear", init_active, 0);
    check("R4 force off", clk_force, 0);
    step(); step();

    // burst 2: tick in arming cycle, then a tick every cycle, request on last tick
    wr_en = 1; wr_data = 1; tick = 1;
    step(); wr_en = 0; wr_data = 0;
    for (int i = 1; i <= LEN; i++) begin
      if (i == LEN) begin
        cmd_req = 1; exp_q.push_back(cyc + 1);
        @(negedge clk); check("R3 arming tick not counted", init_active, 1);
      end
      step();
    end
    tick = 0; cmd_req = 0;
    @(negedge clk); check("R4 clear burst2", init_active, 0);
    repeat (5) step();
    check("R9 all starts seen", exp_q.size(), 0);
    finish_run();
  end
endmodule